// File: doc/BRIEF.md
# SAR Converter Parallel Readout Controller

This block is a synchronous controller for an external 16-bit successive-approximation converter that has a parallel data interface. It drives the active-low conversion-start strobe, chip select, read strobe and half-word select. It watches the converter's busy line through a synchronizer. After each conversion it reads the result and hands the sample to the core as a single-cycle valid pulse with the 16-bit word. Readout has zero latency: the word delivered always belongs to the conversion that has just ended.

Minimum pulse widths and gaps are given in nanoseconds. They are turned into clock cycles by rounding up against a clock-period parameter. The result is read either as one full-width word or as two half-width reads, upper half first. An abort input restarts a running conversion once enough time has passed since its start edge. A watchdog ends any conversion whose busy phase never completes, and the controller then returns to idle.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset the start strobe, chip select and read strobe are high, the half select is low, and the valid and timeout outputs are low.
- R2: A one-cycle pulse on `sample_req_i` starts one conversion cycle. Requests that arrive while a cycle is running merge into a single pending request, which starts exactly one more cycle after the current one ends.
- R3: Chip select is low for at least one cycle before the start strobe falls. The read strobe is low only while chip select is low.
- R4: Each low pulse of the start strobe lasts at least ceil(CONVST_LO_NS / clock period) cycles. Between two falling edges the strobe stays high for at least ceil(CONVST_HI_NS / clock period) cycles.
- R5: Reading begins only after the busy input has risen and then fallen. The read strobe is never low while the busy input is high.
- R6: In word mode (`byte_mode_i` = 0) each cycle makes exactly one read, with the half select held low. The read strobe is low for at least ceil(RD_LO_NS / clock period) cycles. `smp_data_o` equals all 16 bits sampled on `adc_data_i`, and `smp_valid_o` is high for exactly one cycle.
- R7: In byte mode (`byte_mode_i` = 1) each cycle makes two reads. Both halves are taken from `adc_data_i[15:8]`. The first read has the half select low and returns result bits [15:8]. The second has it high and returns bits [7:0]. The read strobe stays high for at least ceil(RD_HI_NS / clock period) cycles between the two reads. The output word is {first, second}.
- R8: The next start strobe falls at least ceil(ACQ_NS / clock period) cycles after the busy input fell.
- R9: With `abort_i` high, the busy input high, and at least ceil(ABORT_NS / clock period) cycles since the last start edge, the start strobe falls again. The sample delivered is the result of the restarted conversion. Outside a running conversion, `abort_i` does nothing.
- R10: If busy has not completed TIMEOUT_CYC cycles after the start edge, `timeout_o` pulses for one cycle and chip select returns high. No valid is produced, and the controller accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_req_i | input | 1 | Request one conversion |
| byte_mode_i | input | 1 | 1: two half-width reads; 0: one full-width read |
| abort_i | input | 1 | Restart the running conversion when allowed |
| adc_busy_i | input | 1 | Converter busy, asynchronous |
| adc_data_i | input | 16 | Converter parallel data |
| adc_convst_n_o | output | 1 | Conversion start strobe, active low |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_byte_o | output | 1 | Half select: 0 upper half, 1 lower half |
| smp_valid_o | output | 1 | One-cycle sample strobe |
| smp_data_o | output | 16 | Assembled sample |
| timeout_o | output | 1 | One-cycle watchdog error pulse |

## Verification
The bench targets abort timing. It raises abort as soon as the strobe falls and holds it until the restart happens. A design that honoured the request early would restart before the minimum delay. A design that latched the first result would deliver a stale word instead of the restarted conversion's value. In byte mode the converter stub swaps which half it drives according to the half select, so swapped halves or a select that changes at the wrong moment produce a data mismatch. Requests sent in bursts during a running cycle check that a design neither drops the pending start nor runs it twice. A converter that never raises busy must yield a timeout with no valid, and the next request must still complete normally.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_START,
    S_WAIT,
    S_RD_LO,
    S_RD_HI,
    S_DONE,
    S_ACQ
  } rd_state_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned t;
    t = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_busy_sync.sv
module sar_busy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_cycle_counter.sv
module sar_cycle_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!at_top) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sar_word_assembler.sv
module sar_word_assembler #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              split_i,
  input  logic              lower_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [HALF-1:0]   upper_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      word_q  <= '0;
    end else if (cap_i) begin
      if (split_i && !lower_i) upper_q <= bus_i[DATA_W-1 -: HALF];
      else if (split_i)        word_q  <= {upper_q, bus_i[DATA_W-1 -: HALF]};
      else                     word_q  <= bus_i;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_rd_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned CLK_PS       = 4000,
  parameter int unsigned CONVST_LO_NS = 20,
  parameter int unsigned CONVST_HI_NS = 20,
  parameter int unsigned ABORT_NS     = 60,
  parameter int unsigned RD_LO_NS     = 50,
  parameter int unsigned RD_HI_NS     = 20,
  parameter int unsigned ACQ_NS       = 150,
  parameter int unsigned TIMEOUT_CYC  = 512,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_req_i,
  input  logic              byte_mode_i,
  input  logic              abort_i,
  input  logic              adc_busy_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_convst_n_o,
  output logic              adc_cs_n_o,
  output logic              adc_rd_n_o,
  output logic              adc_byte_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              timeout_o
);

  localparam int unsigned LO_CYC   = ns_to_cyc(CONVST_LO_NS, CLK_PS);
  localparam int unsigned HI_CYC   = ns_to_cyc(CONVST_HI_NS, CLK_PS);
  localparam int unsigned AB_CYC   = ns_to_cyc(ABORT_NS, CLK_PS);
  localparam int unsigned RDL_CYC  = ns_to_cyc(RD_LO_NS, CLK_PS);
  localparam int unsigned RDH_CYC  = ns_to_cyc(RD_HI_NS, CLK_PS);
  localparam int unsigned ACQ_CYC  = ns_to_cyc(ACQ_NS, CLK_PS);
  localparam int unsigned PH_MAX   = max2(max2(LO_CYC, RDL_CYC), max2(RDH_CYC, ACQ_CYC));
  localparam int unsigned PH_W     = $clog2(PH_MAX + 1) + 1;
  localparam int unsigned WD_W     = $clog2(max2(TIMEOUT_CYC, max2(AB_CYC, LO_CYC)) + 1) + 1;
  localparam int unsigned HI_W     = $clog2(HI_CYC + 1) + 1;

  rd_state_t state_q, state_d;

  // named internal events
  logic            busy_s;
  logic            state_chg;
  logic            enter_start;
  logic            phase_end;
  logic            hi_ok;
  logic            abort_ok;
  logic            conv_done;
  logic            wd_expired;
  logic            take_req;
  logic            cap_en;
  logic [PH_W-1:0] phase_cnt;
  logic [WD_W-1:0] wd_cnt;
  logic [HI_W-1:0] hi_cnt;

  logic pend_q;
  logic seen_busy_q;
  logic split_q;
  logic lower_q;
  logic convst_n_q, cs_n_q, rd_n_q, valid_q, timeout_q;

  sar_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (adc_busy_i),
    .sync_o  (busy_s)
  );

  assign state_chg   = (state_d != state_q);
  assign enter_start = (state_d == S_START) && (state_q != S_START);

  sar_cycle_counter #(.W(PH_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state_chg),
    .cnt_o (phase_cnt)
  );

  sar_cycle_counter #(.W(WD_W)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (enter_start),
    .cnt_o (wd_cnt)
  );

  sar_cycle_counter #(.W(HI_W)) u_high (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!convst_n_q),
    .cnt_o (hi_cnt)
  );

  always_comb begin
    unique case (state_q)
      S_START: phase_end = (phase_cnt == PH_W'(LO_CYC - 1));
      S_RD_LO: phase_end = (phase_cnt == PH_W'(RDL_CYC - 1));
      S_RD_HI: phase_end = (phase_cnt == PH_W'(RDH_CYC - 1));
      S_ACQ:   phase_end = (phase_cnt == PH_W'(ACQ_CYC - 1));
      default: phase_end = 1'b1;
    endcase
  end

  assign hi_ok      = (hi_cnt >= HI_W'(HI_CYC - 1));
  assign wd_expired = (state_q == S_WAIT) && (wd_cnt >= WD_W'(TIMEOUT_CYC));
  assign conv_done  = (state_q == S_WAIT) && seen_busy_q && !busy_s;
  assign abort_ok   = (state_q == S_WAIT) && abort_i && busy_s && hi_ok &&
                      (wd_cnt >= WD_W'(AB_CYC));
  assign take_req   = (state_q == S_IDLE) && pend_q;
  assign cap_en     = (state_q == S_RD_LO) && phase_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (pend_q) state_d = S_SETUP;
      S_SETUP: if (hi_ok) state_d = S_START;
      S_START: if (phase_end) state_d = S_WAIT;
      S_WAIT: begin
        if (wd_expired)     state_d = S_IDLE;
        else if (conv_done) state_d = S_RD_LO;
        else if (abort_ok)  state_d = S_START;
      end
      S_RD_LO: if (phase_end) state_d = (split_q && !lower_q) ? S_RD_HI : S_DONE;
      S_RD_HI: if (phase_end) state_d = S_RD_LO;
      S_DONE:  state_d = S_ACQ;
      S_ACQ:   if (phase_end) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      pend_q      <= 1'b0;
      seen_busy_q <= 1'b0;
      split_q     <= 1'b0;
      lower_q     <= 1'b0;
      convst_n_q  <= 1'b1;
      cs_n_q      <= 1'b1;
      rd_n_q      <= 1'b1;
      valid_q     <= 1'b0;
      timeout_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= (pend_q && !take_req) || sample_req_i;

      if (enter_start)                        seen_busy_q <= 1'b0;
      else if ((state_q == S_WAIT) && busy_s) seen_busy_q <= 1'b1;

      if (state_q == S_IDLE) split_q <= byte_mode_i;

      if (state_d == S_RD_HI)                               lower_q <= 1'b1;
      else if ((state_d == S_DONE) || (state_d == S_IDLE)) lower_q <= 1'b0;

      convst_n_q <= (state_d != S_START);
      cs_n_q     <= (state_d == S_IDLE) || (state_d == S_DONE) || (state_d == S_ACQ);
      rd_n_q     <= (state_d != S_RD_LO);
      valid_q    <= (state_d == S_DONE);
      timeout_q  <= wd_expired;
    end
  end

  sar_word_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap_en),
    .split_i (split_q),
    .lower_i (lower_q),
    .bus_i   (adc_data_i),
    .word_o  (smp_data_o)
  );

  assign adc_convst_n_o = convst_n_q;
  assign adc_cs_n_o     = cs_n_q;
  assign adc_rd_n_o     = rd_n_q;
  assign adc_byte_o     = lower_q;
  assign smp_valid_o    = valid_q;
  assign timeout_o      = timeout_q;

  // R3: chip select leads the start edge, read only inside chip select
  p_cs_before_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_convst_n_o) |-> !$past(adc_cs_n_o));

  p_rd_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n_o |-> !adc_cs_n_o);

  // R4: the start pulse has run its minimum width by the watchdog's count
  p_convst_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_convst_n_o) |-> ($past(wd_cnt) >= WD_W'(LO_CYC - 1)));

  // R5: reading starts only after synchronized busy was seen low
  p_rd_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n_o) |-> !$past(busy_s));

  // R6: valid is a single-cycle pulse
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

  p_word_select_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_q && !adc_rd_n_o) |-> !adc_byte_o);

  // R7: the half select never changes while a read is in progress
  p_byte_stable_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_rd_n_o && !$past(adc_rd_n_o)) |-> $stable(adc_byte_o));

  // R10: timeout leaves the converter deselected with no sample
  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (adc_cs_n_o && !smp_valid_o));

endmodule

// File: tb/tb_sar_readout_ctrl.sv
`timescale 1ns/1ps
module tb_sar_readout_ctrl;

  localparam int unsigned CLK_PS  = 4000;
  localparam int unsigned TIMEOUT = 512;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000) / CLK_PS;
    if (c * CLK_PS < ns * 1000) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic logic [15:0] stub_bus(input logic [15:0] w, input logic split,
                                           input logic lower, input logic rd_n);
    if (rd_n)  return 16'hA5C3;
    if (!split) return w;
    return lower ? {w[7:0], 8'h5A} : {w[15:8], 8'h5A};
  endfunction

  localparam int LO  = cyc_of(20);
  localparam int HI  = cyc_of(20);
  localparam int AB  = cyc_of(60);
  localparam int RDL = cyc_of(50);
  localparam int RDH = cyc_of(20);
  localparam int ACQ = cyc_of(150);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_req = 1'b0, byte_mode = 1'b0, abort_in = 1'b0;
  logic st_busy;
  logic [15:0] bus;
  logic convst_n, cs_n, rd_n, bsel, valid, tmo;
  logic [15:0] data;

  always #2 clk = ~clk;

  sar_readout_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sample_req_i(sample_req), .byte_mode_i(byte_mode),
    .abort_i(abort_in), .adc_busy_i(st_busy), .adc_data_i(bus),
    .adc_convst_n_o(convst_n), .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n), .adc_byte_o(bsel),
    .smp_valid_o(valid), .smp_data_o(data), .timeout_o(tmo)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // converter stub
  logic st_dead = 1'b0;
  int   st_len = 140;
  logic st_conv, st_cv_prev;
  int   st_age;
  logic [15:0] st_word, st_pend;

  assign bus = stub_bus(st_word, byte_mode, bsel, rd_n);

  always @(negedge clk) begin
    if (!rst_n) begin
      st_busy <= 1'b0; st_conv <= 1'b0; st_cv_prev <= 1'b1; st_age <= 0;
      st_word <= 16'h0; st_pend <= 16'h0;
    end else begin
      st_cv_prev <= convst_n;
      if (st_cv_prev && !convst_n) begin
        st_conv <= 1'b1; st_age <= 0; st_pend <= 16'($urandom);
      end else if (st_conv) begin
        st_age <= st_age + 1;
        if (!st_dead && st_age == 2) st_busy <= 1'b1;
        if (!st_dead && st_age == st_len) begin
          st_busy <= 1'b0; st_conv <= 1'b0; st_word <= st_pend;
        end
      end
    end
  end

  // protocol monitor
  int lo_w, hi_w, rdl_w, rdh_w, since_fall, since_bfall, reads;
  int n_fall = 0, n_valid = 0, n_tmo = 0, n_abort = 0;
  bit any_fall, bf_flag, p_cv, p_rd, p_cs, p_valid, p_sb, any_read;

  always @(negedge clk) begin
    if (!rst_n) begin
      lo_w = 0; hi_w = 1000; rdl_w = 0; rdh_w = 1000; since_fall = 0; since_bfall = 0;
      reads = 0; any_fall = 0; bf_flag = 0; p_cv = 1; p_rd = 1; p_cs = 1; p_valid = 0; p_sb = 0;
      any_read = 0;
    end else begin
      since_fall++; since_bfall++;
      if (p_sb && !st_busy) begin bf_flag = 1; since_bfall = 0; end
      if (p_cv && !convst_n) begin
        n_fall++;
        if (any_fall) chk(hi_w >= HI, "R4", "strobe high width", hi_w, HI);
        chk(!cs_n && !p_cs, "R3", "cs low before start edge", {p_cs, cs_n}, 0);
        if (st_busy) begin
          n_abort++;
          chk(since_fall >= AB, "R9", "abort delay after start edge", since_fall, AB);
        end else if (bf_flag) begin
          chk(since_bfall >= ACQ, "R8", "acquisition gap", since_bfall, ACQ);
        end
        any_fall = 1; bf_flag = 0; since_fall = 0; lo_w = 0; reads = 0;
      end
      if (!p_cv && convst_n) chk(lo_w >= LO, "R4", "strobe low width", lo_w, LO);
      if (!convst_n) lo_w++; else hi_w = (p_cv) ? hi_w + 1 : 1;
      if (p_rd && !rd_n) begin
        chk(!cs_n, "R3", "read inside chip select", cs_n, 0);
        chk(!st_busy, "R5", "read while busy", st_busy, 0);
        if (byte_mode) begin
          chk(bsel == (reads == 1), "R7", "half select for read", bsel, reads == 1);
          if (reads == 1) chk(rdh_w >= RDH, "R7", "read high gap", rdh_w, RDH);
        end else chk(!bsel, "R6", "half select in word mode", bsel, 0);
        reads++; rdl_w = 0;
      end
      if (!p_rd && rd_n) begin
        chk(rdl_w >= RDL, byte_mode ? "R7" : "R6", "read low width", rdl_w, RDL);
        rdh_w = 0;
      end
      if (!rd_n) rdl_w++; else rdh_w++;
      if (valid) begin
        n_valid++;
        chk(!p_valid, "R6", "valid one cycle", p_valid, 0);
        chk(data == st_word, byte_mode ? "R7" : "R6", "sample word", data, st_word);
        chk(reads == (byte_mode ? 2 : 1), byte_mode ? "R7" : "R6", "reads per cycle", reads, byte_mode ? 2 : 1);
        reads = 0;
      end
      if (tmo) n_tmo++;
      p_cv = convst_n; p_rd = rd_n; p_cs = cs_n; p_valid = valid; p_sb = st_busy;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_req();
    sample_req = 1'b1; tick(1); sample_req = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int v0, t0, k;
    v0 = n_valid; t0 = n_tmo; k = 0;
    while (n_valid == v0 && n_tmo == t0 && k < 3000) begin tick(1); k++; end
    chk(k < 3000, req, "cycle completed", k, 3000);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    int v0, f0;
    void'($urandom(32'h5A17));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(convst_n && cs_n && rd_n, "R1", "strobes high after reset", {convst_n, cs_n, rd_n}, 7);
    chk(!bsel && !valid && !tmo, "R1", "select/valid/timeout low", {bsel, valid, tmo}, 0);

    // R9: abort held in idle has no effect
    f0 = n_fall;
    abort_in = 1'b1; tick(60); abort_in = 1'b0;
    chk(n_fall == f0 && cs_n, "R9", "abort ignored in idle", n_fall - f0, 0);

    // R6 word mode, random timing
    byte_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      st_len = 125 + ($urandom % 38);
      pulse_req(); wait_end("R6");
      tick($urandom % 25);
    end
    wait (cs_n == 1'b1); tick(ACQ + 4);
    // R7 byte mode, random timing
    byte_mode = 1'b1;
    for (int i = 0; i < 20; i++) begin
      st_len = 125 + ($urandom % 38);
      pulse_req(); wait_end("R7");
      tick($urandom % 25);
    end
    tick(ACQ + 4);

    // R2 burst of requests during a running cycle gives exactly one extra sample
    byte_mode = 1'b0; st_len = 130;
    v0 = n_valid;
    pulse_req(); tick(20); pulse_req(); tick(7); pulse_req(); tick(30); pulse_req();
    tick(1500);
    chk(n_valid - v0 == 2, "R2", "samples from request burst", n_valid - v0, 2);

    // R9 abort: held from the start edge, restart must wait the minimum delay
    st_len = 200; f0 = n_fall; v0 = n_valid;
    pulse_req();
    while (n_fall == f0) tick(1);
    abort_in = 1'b1;
    while (n_fall == f0 + 1) tick(1);
    abort_in = 1'b0;
    wait_end("R9");
    chk(n_fall - f0 == 2 && n_valid - v0 == 1, "R9", "restart then one sample",
        (n_fall - f0) * 10 + (n_valid - v0), 21);
    tick(ACQ + 4);

    // R9 abort in byte mode as well
    byte_mode = 1'b1; f0 = n_fall;
    pulse_req();
    while (n_fall == f0) tick(1);
    tick(AB + 8); abort_in = 1'b1;
    while (n_fall == f0 + 1) tick(1);
    abort_in = 1'b0;
    wait_end("R9");
    tick(ACQ + 4);

    // R10 converter never goes busy
    st_dead = 1'b1; v0 = n_valid; f0 = n_tmo;
    pulse_req(); wait_end("R10");
    chk(n_tmo - f0 == 1, "R10", "timeout pulses", n_tmo - f0, 1);
    chk(n_valid == v0, "R10", "no sample on timeout", n_valid - v0, 0);
    tick(1);
    chk(cs_n && convst_n, "R10", "deselected after timeout", {cs_n, convst_n}, 3);
    st_dead = 1'b0; st_len = 140;
    tick(ACQ + 4);
    v0 = n_valid;
    pulse_req(); wait_end("R10");
    chk(n_valid - v0 == 1, "R10", "recovery sample", n_valid - v0, 1);
    tick(ACQ + 10);
    chk(n_abort >= 2, "R9", "aborts observed", n_abort, 2);
    report();
  end

endmodule